// File: doc/BRIEF.md
# Banked byte rotate / fill execute unit

This unit carries out two one-word byte instructions against an 8-bit register file that sits outside it. One turns the addressed byte one place to the right, so the lowest bit comes round into the top position and no carry bit is involved. The other fills the addressed byte with all ones. A neighbouring fetch stage presents a 16-bit instruction word. The unit decodes it and forms a 12-bit file address from the 8-bit field. A per-instruction bit picks one of two ways to do this: a fixed split window, or a 4-bit bank register held inside the unit. The unit then reads the operand through a simple address/data port and writes the result either into the file or into its own working register. The rotate updates a negative flag and a zero flag.

Every instruction takes one instruction cycle of four clocks, named Q1 to Q4. In Q1 the word is captured and decoded. In Q2 the operand is read. In Q3 the result is computed. In Q4 the destination is written. A neighbouring unit loads the bank register through a load strobe. An instruction word that is neither of the two supported forms is flagged and leaves all state alone.

Top module: `rotset_exec`

## Requirements
- R1: While reset is held, phase reads Q1 (code 0), the working register reads 0x00, both flags read 0, and rf_we and unsupported are low. The bank register is 0.
- R2: Phase steps 0,1,2,3,0 (Q1,Q2,Q3,Q4), one step per clock. The instruction word is captured at the clock edge that ends Q1.
- R3: A word whose bits [15:10] are 010000 is a rotate, with d = bit 9, a = bit 8 and f = bits [7:0]. Its result bit n is operand bit n+1, and result bit 7 is operand bit 0. For example, 0xD7 gives 0xEB.
- R4: For a rotate with d=1, the result goes to the file at the addressed location, and the working register is unchanged. For a rotate with d=0, the result goes to the working register at the end of Q4, rf_we stays low, and the file location keeps its value.
- R5: At the end of Q4, a rotate sets the negative flag to result bit 7 and sets the zero flag when the result is 0x00. The working register and both flags change only on the edge that ends Q4.
- R6: A word whose bits [15:9] are 0110100 is a fill, with a = bit 8 and f = bits [7:0]. It writes 0xFF to the addressed location and leaves the flags and the working register unchanged. For example, 0x5A becomes 0xFF.
- R7: With a=0, the address is {0x0, f} for f below 0x80 and {0xF, f} for f of 0x80 or above. The bank register is ignored.
- R8: With a=1, the address is {bank, f}. The bank register takes bsr_value on any clock where bsr_load is high. The address is fixed at the end of Q1.
- R9: Any other word raises unsupported during Q2 to Q4. It causes no file write and leaves the working register and the flags unchanged.
- R10: rf_addr holds the instruction's address, unchanged, throughout Q2 to Q4. rf_we is high only in Q4, and rf_wdata carries the result while rf_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 16 | Instruction word, captured at the end of Q1 |
| bsr_load | input | 1 | Load strobe for the bank register |
| bsr_value | input | 4 | New bank register value |
| rf_addr | output | 12 | Register file address, valid in Q2 to Q4 |
| rf_rdata | input | 8 | Register file read data for rf_addr, sampled at the end of Q2 |
| rf_wdata | output | 8 | Register file write data |
| rf_we | output | 1 | Register file write strobe, Q4 only |
| phase | output | 2 | Current phase, 0 to 3 for Q1 to Q4 |
| wreg | output | 8 | Working register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| unsupported | output | 1 | The current instruction is not supported |

## Verification
The hardest cases to reach from the ports are the ones where the bank register and the access bit disagree. The bank register must be non-zero when an access-mode instruction runs, and a banked fill must land in the same numbered bank slot as an access-mode location. To get there, the stimulus loads the bank register in Q3 of the cycle before an instruction and then mixes a=0 and a=1 words with f on both sides of the 0x80 split. The bench checks every resulting address and every file location it touches, through the write port and its own model of the file. Zero and negative results, d=0 rotates followed by reads of the untouched location, and words one bit away from each valid form complete the set.

// File: rtl/rotset_pkg.sv
package rotset_pkg;

  localparam int INSTR_W = 16;
  localparam int FLD_W   = 8;

  localparam logic [5:0] ROT_PREFIX  = 6'b010000;
  localparam logic [6:0] FILL_PREFIX = 7'b0110100;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ROT  = 2'd1,
    OP_FILL = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  typedef struct packed {
    op_e  op;
    logic to_file;
  } dec_t;

endpackage

// File: rtl/rotset_rst_sync.sv
module rotset_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok_n = sync_q[STAGES-1];

endmodule

// File: rtl/rotset_phase_seq.sv
module rotset_phase_seq
  import rotset_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);

  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    unique case (ph_q)
      PH_Q1:   ph_d = PH_Q2;
      PH_Q2:   ph_d = PH_Q3;
      PH_Q3:   ph_d = PH_Q4;
      default: ph_d = PH_Q1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_Q1;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/rotset_decode.sv
module rotset_decode
  import rotset_pkg::*;
#(
  parameter int               BANK_W       = 4,
  parameter logic [FLD_W-1:0] ACCESS_SPLIT = 8'h80,
  localparam int              ADDR_W       = BANK_W + FLD_W
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [BANK_W-1:0]  bank,
  output dec_t               dec_o,
  output logic [ADDR_W-1:0]  addr_o
);

  logic [FLD_W-1:0]  fld;
  logic              banked;
  logic [BANK_W-1:0] window_bank;

  assign fld    = instr[FLD_W-1:0];
  assign banked = instr[FLD_W];

  always_comb begin
    dec_o.op      = OP_BAD;
    dec_o.to_file = 1'b0;
    if (instr[INSTR_W-1 -: 6] == ROT_PREFIX) begin
      dec_o.op      = OP_ROT;
      dec_o.to_file = instr[FLD_W+1];
    end else if (instr[INSTR_W-1 -: 7] == FILL_PREFIX) begin
      dec_o.op      = OP_FILL;
      dec_o.to_file = 1'b1;
    end
  end

  // Split window: low part of bank 0, high part of the top bank.
  always_comb begin
    if (fld >= ACCESS_SPLIT) begin
      window_bank = {BANK_W{1'b1}};
    end else begin
      window_bank = '0;
    end
  end

  always_comb begin
    if (banked) begin
      addr_o = {bank, fld};
    end else begin
      addr_o = {window_bank, fld};
    end
  end

endmodule

// File: rtl/rotset_alu.sv
module rotset_alu
  import rotset_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] res,
  output logic              neg,
  output logic              zero
);

  logic [DATA_W-1:0] rot;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W - 1; gi++) begin : g_rot
      assign rot[gi] = opnd[gi+1];
    end
  endgenerate
  assign rot[DATA_W-1] = opnd[0];

  always_comb begin
    unique case (op)
      OP_ROT:  res = rot;
      OP_FILL: res = {DATA_W{1'b1}};
      default: res = '0;
    endcase
  end

  assign neg  = res[DATA_W-1];
  assign zero = (res == '0);

endmodule

// File: rtl/rotset_exec.sv
module rotset_exec
  import rotset_pkg::*;
#(
  parameter int               BANK_W       = 4,
  parameter int               DATA_W       = 8,
  parameter logic [FLD_W-1:0] ACCESS_SPLIT = 8'h80,
  parameter int               RST_STAGES   = 2,
  localparam int              ADDR_W       = BANK_W + FLD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic               bsr_load,
  input  logic [BANK_W-1:0]  bsr_value,
  output logic [ADDR_W-1:0]  rf_addr,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               rf_we,
  output logic [1:0]         phase,
  output logic [DATA_W-1:0]  wreg,
  output logic               flag_n,
  output logic               flag_z,
  output logic               unsupported
);

  logic              rst_ok_n;
  phase_e            ph;

  dec_t              dec_new;
  logic [ADDR_W-1:0] addr_new;
  logic [DATA_W-1:0] alu_res;
  logic              alu_neg;
  logic              alu_zero;

  dec_t              ir_q,    ir_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] opnd_q,  opnd_d;
  logic [DATA_W-1:0] res_q,   res_d;
  logic              rn_q,    rn_d;
  logic              rz_q,    rz_d;
  logic [DATA_W-1:0] wreg_q,  wreg_d;
  logic              n_q,     n_d;
  logic              z_q,     z_d;
  logic [BANK_W-1:0] bank_q,  bank_d;

  logic              op_live;
  logic              en_dec;
  logic              en_opnd;
  logic              en_res;
  logic              goes_to_file;
  logic              en_wreg;
  logic              en_flags;

  rotset_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  rotset_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_ok_n),
    .phase_o (ph)
  );

  rotset_decode #(
    .BANK_W       (BANK_W),
    .ACCESS_SPLIT (ACCESS_SPLIT)
  ) u_dec (
    .instr  (instr),
    .bank   (bank_q),
    .dec_o  (dec_new),
    .addr_o (addr_new)
  );

  rotset_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op   (ir_q.op),
    .opnd (opnd_q),
    .res  (alu_res),
    .neg  (alu_neg),
    .zero (alu_zero)
  );

  // Clock enables, one per phase action.
  assign op_live      = (ir_q.op == OP_ROT) || (ir_q.op == OP_FILL);
  assign en_dec       = (ph == PH_Q1);
  assign en_opnd      = (ph == PH_Q2) && (ir_q.op == OP_ROT);
  assign en_res       = (ph == PH_Q3) && op_live;
  assign goes_to_file = ((ir_q.op == OP_ROT) && ir_q.to_file) || (ir_q.op == OP_FILL);
  assign en_wreg      = (ph == PH_Q4) && (ir_q.op == OP_ROT) && !ir_q.to_file;
  assign en_flags     = (ph == PH_Q4) && (ir_q.op == OP_ROT);

  always_comb begin
    ir_d   = ir_q;
    addr_d = addr_q;
    opnd_d = opnd_q;
    res_d  = res_q;
    rn_d   = rn_q;
    rz_d   = rz_q;
    wreg_d = wreg_q;
    n_d    = n_q;
    z_d    = z_q;
    bank_d = bank_q;
    if (en_dec) begin
      ir_d   = dec_new;
      addr_d = addr_new;
    end
    if (en_opnd) begin
      opnd_d = rf_rdata;
    end
    if (en_res) begin
      res_d = alu_res;
      rn_d  = alu_neg;
      rz_d  = alu_zero;
    end
    if (en_wreg) begin
      wreg_d = res_q;
    end
    if (en_flags) begin
      n_d = rn_q;
      z_d = rz_q;
    end
    if (bsr_load) begin
      bank_d = bsr_value;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      ir_q   <= '{op: OP_IDLE, to_file: 1'b0};
      addr_q <= '0;
      opnd_q <= '0;
      res_q  <= '0;
      rn_q   <= 1'b0;
      rz_q   <= 1'b0;
      wreg_q <= '0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
      bank_q <= '0;
    end else begin
      ir_q   <= ir_d;
      addr_q <= addr_d;
      opnd_q <= opnd_d;
      res_q  <= res_d;
      rn_q   <= rn_d;
      rz_q   <= rz_d;
      wreg_q <= wreg_d;
      n_q    <= n_d;
      z_q    <= z_d;
      bank_q <= bank_d;
    end
  end

  assign rf_addr     = ((ph != PH_Q1) && op_live) ? addr_q : '0;
  assign rf_we       = (ph == PH_Q4) && goes_to_file;
  assign rf_wdata    = rf_we ? res_q : '0;
  assign phase       = ph;
  assign wreg        = wreg_q;
  assign flag_n      = n_q;
  assign flag_z      = z_q;
  assign unsupported = (ph != PH_Q1) && (ir_q.op == OP_BAD);

endmodule

module rotset_exec_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [1:0]        phase,
  input logic              rf_we,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              unsupported,
  input logic [DATA_W-1:0] wreg,
  input logic              flag_n,
  input logic              flag_z
);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> phase == $past(phase) + 2'd1);

  p_write_in_q4_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    rf_we |-> phase == 2'd3);

  p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (phase == 2'd2 || phase == 2'd3) |-> $stable(rf_addr));

  p_state_moves_after_q4_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (phase != 2'd0) |-> $stable({wreg, flag_n, flag_z}));

  p_unsup_no_write_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    unsupported |-> !rf_we);

  p_unsup_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (unsupported && phase == 2'd3) |=> $stable({wreg, flag_n, flag_z}));

  p_file_dest_keeps_wreg_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    rf_we |=> $stable(wreg));

endmodule

bind rotset_exec rotset_exec_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_ok      (rst_ok_n),
  .phase       (phase),
  .rf_we       (rf_we),
  .rf_addr     (rf_addr),
  .unsupported (unsupported),
  .wreg        (wreg),
  .flag_n      (flag_n),
  .flag_z      (flag_z)
);

// File: tb/rotset_exec_test.sv
module rotset_exec_test;

  localparam int CLK_P  = 10;
  localparam int BANK_W = 4;
  localparam int ADDR_W = BANK_W + 8;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              we;
    logic [7:0]        wdata;
    logic              unsup;
    logic [7:0]        wreg;
    logic              n;
    logic              z;
    logic [7:0]        mval;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       instr;
  logic              bsr_load;
  logic [BANK_W-1:0] bsr_value;
  logic [ADDR_W-1:0] rf_addr;
  logic [7:0]        rf_rdata;
  logic [7:0]        rf_wdata;
  logic              rf_we;
  logic [1:0]        phase;
  logic [7:0]        wreg;
  logic              flag_n;
  logic              flag_z;
  logic              unsupported;

  logic [7:0] mem   [DEPTH];
  logic [7:0] m_mem [DEPTH];
  logic [BANK_W-1:0] m_bank;
  logic [7:0]        m_wreg;
  logic              m_n, m_z;

  item_t sb [$];
  string tags [$];
  bit    seen_q4 = 1'b0;
  bit    finished = 1'b0;
  int    total = 0;
  int    bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rotset_exec uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr       (instr),
    .bsr_load    (bsr_load),
    .bsr_value   (bsr_value),
    .rf_addr     (rf_addr),
    .rf_rdata    (rf_rdata),
    .rf_wdata    (rf_wdata),
    .rf_we       (rf_we),
    .phase       (phase),
    .wreg        (wreg),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .unsupported (unsupported)
  );

  // External register file model
  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] rot_w(input logic [7:0] f, input logic d, input logic a);
    return {6'b010000, d, a, f};
  endfunction

  function automatic logic [15:0] fill_w(input logic [7:0] f, input logic a);
    return {7'b0110100, a, f};
  endfunction

  task automatic exec(input logic [15:0] ins, input string tag);
    item_t e;
    logic [ADDR_W-1:0] a;
    logic [7:0] v, r;
    @(negedge clk);
    while (phase != 2'd0) @(negedge clk);
    instr = ins;
    if (ins[8]) a = {m_bank, ins[7:0]};
    else if (ins[7]) a = {4'hF, ins[7:0]};
    else a = {4'h0, ins[7:0]};
    e = '0;
    e.addr = a;
    if (ins[15:10] == 6'b010000) begin
      v = m_mem[a];
      r = {v[0], v[7:1]};
      m_n = r[7];
      m_z = (r == 8'h00);
      if (ins[9]) begin
        e.we = 1'b1; e.wdata = r; m_mem[a] = r;
      end else begin
        m_wreg = r;
      end
    end else if (ins[15:9] == 7'b0110100) begin
      e.we = 1'b1; e.wdata = 8'hFF; m_mem[a] = 8'hFF;
    end else begin
      e.unsup = 1'b1;
    end
    e.wreg = m_wreg; e.n = m_n; e.z = m_z; e.mval = m_mem[a];
    sb.push_back(e);
    tags.push_back(tag);
    @(negedge clk);
    instr = 16'h0000;
  endtask

  task automatic load_bank(input logic [BANK_W-1:0] b);
    @(negedge clk);
    while (phase != 2'd2) @(negedge clk);
    bsr_load = 1'b1;
    bsr_value = b;
    @(negedge clk);
    bsr_load = 1'b0;
    m_bank = b;
  endtask

  // Monitor: compares design outputs with the scoreboard front
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t e;
      string t;
      e = sb[0];
      t = tags[0];
      if (phase == 2'd1 || phase == 2'd2) begin
        chk(rf_we == 1'b0, {t, " R10 we outside Q4"}, rf_we, 0);
      end else if (phase == 2'd3) begin
        chk(unsupported == e.unsup, {t, " R9 unsupported"}, unsupported, e.unsup);
        chk(rf_we == e.we, {t, " R4 rf_we"}, rf_we, e.we);
        if (e.we) chk(rf_wdata == e.wdata, {t, " R10 wdata"}, rf_wdata, e.wdata);
        if (!e.unsup) chk(rf_addr == e.addr, {t, " R7/R8 addr"}, rf_addr, e.addr);
        seen_q4 = 1'b1;
      end else if (phase == 2'd0 && seen_q4) begin
        void'(sb.pop_front());
        void'(tags.pop_front());
        seen_q4 = 1'b0;
        chk(wreg == e.wreg, {t, " R4 wreg"}, wreg, e.wreg);
        chk(flag_n == e.n, {t, " R5 flag_n"}, flag_n, e.n);
        chk(flag_z == e.z, {t, " R5 flag_z"}, flag_z, e.z);
        if (!e.unsup) chk(mem[e.addr] == e.mval, {t, " file value"}, mem[e.addr], e.mval);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr = 16'h0000;
    bsr_load = 1'b0;
    bsr_value = '0;
    m_bank = '0; m_wreg = 8'h00; m_n = 1'b0; m_z = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * 7 + 3);
    end
    mem[12'h020] = 8'hD7; mem[12'h021] = 8'hD7; mem[12'h030] = 8'h5A;
    mem[12'h040] = 8'h00; mem[12'h041] = 8'h01; mem[12'h042] = 8'h02;
    mem[12'hF85] = 8'h81; mem[12'h310] = 8'h34; mem[12'h022] = 8'h44;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = mem[i];

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(phase == 2'd0, "R1 phase", phase, 0);
    chk(wreg == 8'h00, "R1 wreg", wreg, 0);
    chk(flag_n == 1'b0 && flag_z == 1'b0, "R1 flags", {flag_n, flag_z}, 0);
    chk(rf_we == 1'b0, "R1 rf_we", rf_we, 0);
    chk(unsupported == 1'b0, "R1 unsupported", unsupported, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: phase order
    while (phase != 2'd0) @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(phase == 2'(k), "R2 phase step", phase, 2'(k));
    end

    exec(rot_w(8'h20, 1'b1, 1'b0), "R3 rotate D7 to file");
    exec(rot_w(8'h21, 1'b0, 1'b0), "R4 rotate D7 to wreg");
    exec(fill_w(8'h30, 1'b0), "R6 fill 5A");
    exec(rot_w(8'h85, 1'b1, 1'b0), "R7 access high window");
    load_bank(4'h3);
    exec(rot_w(8'h22, 1'b1, 1'b0), "R7 bank ignored");
    exec(rot_w(8'h10, 1'b1, 1'b1), "R8 banked rotate");
    exec(fill_w(8'h90, 1'b1), "R8 banked fill");
    exec(rot_w(8'h40, 1'b1, 1'b0), "R5 zero result");
    exec(rot_w(8'h41, 1'b1, 1'b0), "R5 negative result");
    exec(16'h4400, "R9 near rotate");
    exec(16'h6A05, "R9 near fill");
    exec(fill_w(8'hFF, 1'b0), "R6 fill top address");
    exec(rot_w(8'h42, 1'b0, 1'b0), "R4 rotate 02 to wreg");
    exec(rot_w(8'h21, 1'b1, 1'b0), "R4 source kept after d0");
    load_bank(4'hA);
    exec(fill_w(8'h05, 1'b1), "R8 second bank");

    repeat (12) @(negedge clk);
    chk(sb.size() == 0, "R2 all items retired", sb.size(), 0);
    chk(mem[12'h020] == 8'hEB, "R3 D7 gives EB", mem[12'h020], 8'hEB);
    chk(mem[12'h030] == 8'hFF, "R6 5A gives FF", mem[12'h030], 8'hFF);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule